// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

A register-mapped controller that gives an 8-bit processor bus three 8-bit general-purpose parallel ports. Each port owns a data latch and a direction mask. It also has two write-only addresses. One clears selected latch bits and the other sets selected latch bits, so software can flip single lines without a read-modify-write sequence that could race with other code.

A port read merges two sources bit by bit. Output bits come from the stored latch and input bits come from the live pin value. The pins are driven through a value/enable pair per port, which suits a pad ring with separate output-enable controls. A mode byte is stored and can be read back but has no effect on port behaviour. The register map is fixed and sparse, and the offset is 5 bits wide.

Top module: `pio_tri_port`

## Requirements
- R1: After rst_ni is asserted low, every data latch, every direction mask and the mode byte are 0. All oe_*_o outputs are 0 and all pin_*_o outputs are 0.
- R2: The map for ports A, B and C is fixed and is decoded from addr_i[4:0]:
  - data registers at 0x00, 0x01 and 0x02;
  - direction registers at 0x04, 0x05 and 0x06;
  - the mode byte at 0x07;
  - bit-clear registers at 0x08, 0x09 and 0x0A;
  - bit-set registers at 0x0C, 0x0D and 0x0E.
- R3: A write (wr_i high at a rising clk_i edge) to a data register stores all 8 bits of wdata_i in that port's latch. The port's pin output then equals latch AND direction, so a later direction change exposes the stored bits.
- R4: A write to a bit-clear register clears the latch bits where wdata_i is 1 and keeps the other latch bits.
- R5: A write to a bit-set register sets the latch bits where wdata_i is 1 and keeps the other latch bits.
- R6: While rd_i is high at a data register offset, rdata_o equals (latch AND dir) OR (pin input AND NOT dir), combinationally in the same cycle.
- R7: A direction bit of 1 makes the pin an output (oe bit 1) and a direction bit of 0 makes it an input. A write to a direction register stores wdata_i, and a read of that offset returns it.
- R8: A read of 0x07 returns the last value written to the mode byte. The mode byte changes neither the latches nor the pin outputs.
- R9: Reads of unused offsets (0x03, 0x0B, 0x0F, 0x10 to 0x1F) and of the write-only bit-clear and bit-set offsets return 0xFF. Writes to unused offsets change no register.
- R10: While rd_i is low, rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pin_a_i | input | 8 | Port A live pin values |
| pin_b_i | input | 8 | Port B live pin values |
| pin_c_i | input | 8 | Port C live pin values |
| pin_a_o | output | 8 | Port A output values |
| pin_b_o | output | 8 | Port B output values |
| pin_c_o | output | 8 | Port C output values |
| oe_a_o | output | 8 | Port A output enables |
| oe_b_o | output | 8 | Port B output enables |
| oe_c_o | output | 8 | Port C output enables |

## Verification
Each port is swept through all 256 latch values. For each value the direction mask is a fixed transform of it and the pin inputs are its complement, so every bit position is read both as latch and as pin. A swapped merge term or a crossed port index shows up as a mismatch. A second sweep chains bit-clear and bit-set writes against a running model of each latch; this separates an AND-NOT from a plain overwrite and shows whether writes leak into neighbouring bits. All 32 offsets are then read, and junk is written to every unused offset. After that, every readable register is read back to show that no write reached it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 5;
  localparam int unsigned NPORT = 3;
  localparam int unsigned PW    = 2;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DATA,
    ACC_DIR,
    ACC_CLR,
    ACC_SET,
    ACC_MODE
  } acc_e;

  typedef struct packed {
    acc_e          kind;
    logic [PW-1:0] port;
  } dec_t;

  // offsets [3:2] pick the group, [1:0] the port; slot 3 is mode in the dir group
  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    d.port = a[1:0];
    d.kind = ACC_NONE;
    if (a[4] == 1'b0) begin
      unique case (a[3:2])
        2'b00: d.kind = (a[1:0] == 2'd3) ? ACC_NONE : ACC_DATA;
        2'b01: d.kind = (a[1:0] == 2'd3) ? ACC_MODE : ACC_DIR;
        2'b10: d.kind = (a[1:0] == 2'd3) ? ACC_NONE : ACC_CLR;
        default: d.kind = (a[1:0] == 2'd3) ? ACC_NONE : ACC_SET;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/pio_dec.sv
module pio_dec
  import pio_pkg::*;
#(
  parameter int unsigned AW_P = pio_pkg::AW
) (
  input  logic [AW_P-1:0] addr_i,
  output dec_t            dec_o
);
  always_comb dec_o = decode(addr_i);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned DW_P = pio_pkg::DW,
  parameter int unsigned IDX  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  dec_t            dec_i,
  input  logic [DW_P-1:0] wdata_i,
  output logic [DW_P-1:0] latch_o,
  output logic [DW_P-1:0] dir_o
);
  localparam logic [PW-1:0] MY_IDX = PW'(IDX);

  logic mine;
  assign mine = wr_i && (dec_i.port == MY_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
    end else if (mine) begin
      unique case (dec_i.kind)
        ACC_DATA: latch_o <= wdata_i;
        ACC_CLR:  latch_o <= latch_o & ~wdata_i;
        ACC_SET:  latch_o <= latch_o | wdata_i;
        ACC_DIR:  dir_o   <= wdata_i;
        default: ;
      endcase
    end
  end

  // R4
  a_r4_clear_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && dec_i.kind == ACC_CLR) |=> latch_o == ($past(latch_o) & ~$past(wdata_i)));
  // R5
  a_r5_set_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && dec_i.kind == ACC_SET) |=> latch_o == ($past(latch_o) | $past(wdata_i)));
  // R9
  a_r9_latch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mine && (dec_i.kind inside {ACC_DATA, ACC_CLR, ACC_SET})) |=> $stable(latch_o));
  // R7
  a_r7_dir_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mine && dec_i.kind == ACC_DIR) |=> $stable(dir_o));
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int unsigned DW_P = pio_pkg::DW,
  parameter int unsigned NP_P = pio_pkg::NPORT
) (
  input  logic                      rd_i,
  input  dec_t                      dec_i,
  input  logic [NP_P-1:0][DW_P-1:0] latch_i,
  input  logic [NP_P-1:0][DW_P-1:0] dir_i,
  input  logic [NP_P-1:0][DW_P-1:0] pin_i,
  input  logic [DW_P-1:0]           mode_i,
  output logic [DW_P-1:0]           rdata_o
);
  logic [NP_P-1:0][DW_P-1:0] merged;
  logic                      port_ok;
  logic [DW_P-1:0]           sel;

  for (genvar g = 0; g < NP_P; g++) begin : g_merge
    assign merged[g] = (latch_i[g] & dir_i[g]) | (pin_i[g] & ~dir_i[g]);
  end

  assign port_ok = 32'(dec_i.port) < NP_P;

  always_comb begin
    sel = '1;
    unique case (dec_i.kind)
      ACC_DATA: if (port_ok) sel = merged[dec_i.port];
      ACC_DIR:  if (port_ok) sel = dir_i[dec_i.port];
      ACC_MODE: sel = mode_i;
      default:  sel = '1;
    endcase
    rdata_o = rd_i ? sel : '0;
  end
endmodule

// File: rtl/pio_tri_port.sv
module pio_tri_port
  import pio_pkg::*;
#(
  parameter int unsigned DW_P = pio_pkg::DW,
  parameter int unsigned AW_P = pio_pkg::AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW_P-1:0] addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW_P-1:0] wdata_i,
  output logic [DW_P-1:0] rdata_o,
  input  logic [DW_P-1:0] pin_a_i,
  input  logic [DW_P-1:0] pin_b_i,
  input  logic [DW_P-1:0] pin_c_i,
  output logic [DW_P-1:0] pin_a_o,
  output logic [DW_P-1:0] pin_b_o,
  output logic [DW_P-1:0] pin_c_o,
  output logic [DW_P-1:0] oe_a_o,
  output logic [DW_P-1:0] oe_b_o,
  output logic [DW_P-1:0] oe_c_o
);
  localparam int unsigned NP = pio_pkg::NPORT;

  dec_t                    dec;
  logic [NP-1:0][DW_P-1:0] latch;
  logic [NP-1:0][DW_P-1:0] dir;
  logic [NP-1:0][DW_P-1:0] pins;
  logic [DW_P-1:0]         mode_q;

  pio_dec #(.AW_P(AW_P)) i_dec (.addr_i(addr_i), .dec_o(dec));

  for (genvar g = 0; g < NP; g++) begin : g_port
    pio_port #(.DW_P(DW_P), .IDX(g)) i_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i),
      .dec_i   (dec),
      .wdata_i (wdata_i),
      .latch_o (latch[g]),
      .dir_o   (dir[g])
    );
  end

  // stored only; no effect on port behaviour
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mode_q <= '0;
    else if (wr_i && dec.kind == ACC_MODE) mode_q <= wdata_i;
  end

  assign pins = {pin_c_i, pin_b_i, pin_a_i};

  pio_rd_mux #(.DW_P(DW_P), .NP_P(NP)) i_rd_mux (
    .rd_i    (rd_i),
    .dec_i   (dec),
    .latch_i (latch),
    .dir_i   (dir),
    .pin_i   (pins),
    .mode_i  (mode_q),
    .rdata_o (rdata_o)
  );

  assign pin_a_o = latch[0] & dir[0];
  assign pin_b_o = latch[1] & dir[1];
  assign pin_c_o = latch[2] & dir[2];
  assign oe_a_o  = dir[0];
  assign oe_b_o  = dir[1];
  assign oe_c_o  = dir[2];

  // R10
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
  // R9
  a_r9_high_ofs_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[AW_P-1]) |-> rdata_o == '1);
  // R8
  a_r8_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == AW_P'(7)) |=> $stable(mode_q));
  // R6
  a_r6_input_pin_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0 && oe_a_o == '0) |-> rdata_o == pin_a_i);
endmodule

// File: tb/test_pio_tri_port.sv
`timescale 1ns/1ps
module test_pio_tri_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin_in [3];
  logic [7:0] pin_out [3];
  logic [7:0] oe [3];

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] m_latch [3];
  logic [7:0] m_dir [3];
  logic [7:0] m_mode;

  always #4 clk = ~clk;

  pio_tri_port i_pio_tri_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata),
    .pin_a_i(pin_in[0]), .pin_b_i(pin_in[1]), .pin_c_i(pin_in[2]),
    .pin_a_o(pin_out[0]), .pin_b_o(pin_out[1]), .pin_c_o(pin_out[2]),
    .oe_a_o(oe[0]), .oe_b_o(oe[1]), .oe_c_o(oe[2])
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  function automatic logic [7:0] merge(input int p);
    return (m_latch[p] & m_dir[p]) | (pin_in[p] & ~m_dir[p]);
  endfunction

  initial begin
    logic [7:0] d;
    for (int p = 0; p < 3; p++) begin
      pin_in[p] = 8'h3C + 8'(p);
      m_latch[p] = '0; m_dir[p] = '0;
    end
    m_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int p = 0; p < 3; p++) begin
      chk("R1 oe", oe[p], 8'h00);
      chk("R1 pin_o", pin_out[p], 8'h00);
      rd_reg(5'(p), d);     chk("R1 data reads pins", d, pin_in[p]);
      rd_reg(5'(4 + p), d); chk("R1 dir", d, 8'h00);
    end
    rd_reg(5'h07, d); chk("R1 mode", d, 8'h00);
    // R10 idle bus
    #1 chk("R10 idle rdata", rdata, 8'h00);

    // R3 R6 R7 sweep over all latch values per port
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 256; v++) begin
        m_latch[p] = 8'(v);
        m_dir[p]   = 8'(v) ^ 8'h5A;
        pin_in[p]  = ~8'(v);
        wr_reg(5'(p), m_latch[p]);
        wr_reg(5'(4 + p), m_dir[p]);
        rd_reg(5'(p), d);      chk("R6 merged read", d, merge(p));
        chk("R3 pin_o", pin_out[p], m_latch[p] & m_dir[p]);
        chk("R7 oe", oe[p], m_dir[p]);
        if (v % 16 == 0) begin
          rd_reg(5'(4 + p), d); chk("R7 dir readback", d, m_dir[p]);
        end
      end
      // R3 stored bits exposed by direction change
      wr_reg(5'(4 + p), 8'h00);
      wr_reg(5'(p), 8'hC3);
      chk("R3 hidden", pin_out[p], 8'h00);
      wr_reg(5'(4 + p), 8'hFF);
      chk("R3 exposed", pin_out[p], 8'hC3);
      m_latch[p] = 8'hC3; m_dir[p] = 8'hFF;
    end

    // R4 R5 chained bit-clear/bit-set against model
    for (int v = 0; v < 256; v++) begin
      int p;
      logic [7:0] cm, sm;
      p  = v % 3;
      cm = 8'(v * 37 + 11);
      sm = 8'(v * 73 + 5);
      wr_reg(5'(8 + p), cm);
      m_latch[p] = m_latch[p] & ~cm;
      chk("R4 clear", pin_out[p], m_latch[p]);
      wr_reg(5'(12 + p), sm);
      m_latch[p] = m_latch[p] | sm;
      chk("R5 set", pin_out[p], m_latch[p]);
    end

    // R8 mode byte stored, no effect
    wr_reg(5'h07, 8'h96); m_mode = 8'h96;
    rd_reg(5'h07, d); chk("R8 mode readback", d, 8'h96);
    for (int p = 0; p < 3; p++) chk("R8 no effect", pin_out[p], m_latch[p]);

    // R2 R9 full offset sweep
    for (int a = 0; a < 32; a++) begin
      logic [7:0] e;
      e = 8'hFF;
      if (a < 3) e = merge(a);
      else if (a >= 4 && a < 7) e = m_dir[a - 4];
      else if (a == 7) e = m_mode;
      rd_reg(5'(a), d);
      chk((a < 8) ? "R2 map read" : "R9 unused or write-only", d, e);
    end
    for (int a = 0; a < 32; a++) begin
      if (a == 3 || a == 11 || a == 15 || a >= 16) wr_reg(5'(a), 8'hA5);
    end
    for (int p = 0; p < 3; p++) begin
      rd_reg(5'(p), d);     chk("R9 latch untouched", d, merge(p));
      rd_reg(5'(4 + p), d); chk("R9 dir untouched", d, m_dir[p]);
      chk("R9 pin_o untouched", pin_out[p], m_latch[p] & m_dir[p]);
    end
    rd_reg(5'h07, d); chk("R9 mode untouched", d, m_mode);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule